// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs read and write cycles on an external asynchronous bus for SRAM, ROM or memory-mapped peripherals. It serves four chip-select banks. A host issues one request at a time. Each request carries a bank number, a byte offset, a direction flag and up to four 16-bit write beats. The block runs a cycle-counted sequence of phases: address setup, chip-select setup, strobe access, optional page beats, chip-select hold and address hold. When the whole sequence is done it pulses an acknowledge for one cycle.

Each bank has its own six timing counts, its own data width (one or two bytes) and its own page-mode flag. These come from static configuration inputs. The configuration of the selected bank is captured at the moment a request is accepted. In page mode one access moves four data items. The address steps by the bank width on each beat, and the strobe stays low throughout.

Top module: `smc_top`

## Requirements
- R1: After reset all chip selects (`mem_cs_n`), `mem_oe_n` and `mem_we_n` are high, `mem_doe` and `ack` are 0, and `mem_addr` is 0.
- R2: A request is accepted on a clock edge where `req_valid` is high and the block is idle. For the next `tacs` cycles (0..15), `mem_addr` shows the offset while every chip select stays high. After that only `mem_cs_n[b]` goes low, where bit index b equals the bank number.
- R3: The chip select is low for `tcos` cycles (0..15) before the strobe goes low. The strobe is `mem_oe_n` on reads and `mem_we_n` on writes, and the two are never low together.
- R4: The first strobe phase lasts `tacc`+1 cycles, with `tacc` a 5-bit count (0..31).
- R5: When the bank's page flag is set, three more beats follow with the strobe still low. Each beat lasts `tacp` cycles, with a value of 0 acting as 1. Each beat advances `mem_addr` by 1 for an 8-bit bank or by 2 for a 16-bit bank.
- R6: After the strobe rises, the chip select stays low for `tcoh` cycles. It then rises, and `mem_addr` is held for `tcah` more cycles.
- R7: `ack` is high for exactly one cycle, the cycle right after the address hold ends. A phase whose count is zero takes no cycles.
- R8: On reads, `mem_din` is sampled on the last cycle of each beat. Beat k goes to `rdata[16k+15:16k]`. An 8-bit bank returns `mem_din[7:0]` zero-extended. Beats that are not transferred read as zero. `rdata` is valid when `ack` is high.
- R9: On writes, `mem_doe` is high from the chip-select setup phase through the chip-select hold phase. During this window `mem_dout` carries beat k, `req_wdata[16k+15:16k]`, zero-extended from its low byte for an 8-bit bank. Outside this window `mem_doe` is 0 and `mem_dout` is 0.
- R10: A request raised while an access is running, including its `ack` cycle, is ignored.
- R11: Changes to the configuration inputs during an access do not affect that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_bank | input | BANK_W | Bank number of the request |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4*16 | Write beats, beat k in bits 16k+15:16k |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 4*16 | Read beats, valid with ack |
| cfg_tacs | input | NBANK*4 | Address setup count per bank |
| cfg_tcos | input | NBANK*4 | Chip-select-to-strobe count per bank |
| cfg_tacc | input | NBANK*5 | Access count per bank (length is value+1) |
| cfg_tcoh | input | NBANK*4 | Chip-select hold after strobe per bank |
| cfg_tcah | input | NBANK*4 | Address hold after chip select per bank |
| cfg_tacp | input | NBANK*4 | Page beat count per bank |
| cfg_wide | input | NBANK | 1 = 16-bit bank, 0 = 8-bit bank |
| cfg_page | input | NBANK | 1 = four-beat page access |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | NBANK | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | External write data |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 16 | External read data |

## Verification
The first phase cycle shows on the bus in the cycle right after the accepting edge. From there each phase takes exactly its programmed count in cycles. `ack` falls in cycle tacs+tcos+tacc+1+pages+tcoh+tcah after acceptance, where pages is 3·max(tacp,1) or 0. The bench builds from the requirements a list of the expected bus values for each cycle and compares every element at the falling edge of that cycle. It checks `rdata` in the `ack` cycle and the idle state one cycle later. The external memory is a combinational function of the address, so the expected read beats follow from the stepped addresses.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int DW      = 16;
    localparam int BEATS   = 4;
    localparam int BEAT_W  = 2;
    localparam int SHORT_W = 4;
    localparam int ACC_W   = 5;
    localparam int CNT_W   = ACC_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASET,
        PH_CSET,
        PH_ACC,
        PH_PAGE,
        PH_CHOLD,
        PH_AHOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [SHORT_W-1:0] tacs;
        logic [SHORT_W-1:0] tcos;
        logic [ACC_W-1:0]   tacc;
        logic [SHORT_W-1:0] tcoh;
        logic [SHORT_W-1:0] tcah;
        logic [SHORT_W-1:0] tacp;
        logic               page;
    } bank_timing_t;

    // first phase of an access, skipping zero-length setup phases
    function automatic phase_e first_phase(bank_timing_t c);
        if (c.tacs != '0) return PH_ASET;
        if (c.tcos != '0) return PH_CSET;
        return PH_ACC;
    endfunction

    // phase that follows the last strobe beat
    function automatic phase_e tail_phase(bank_timing_t c);
        if (c.tcoh != '0) return PH_CHOLD;
        if (c.tcah != '0) return PH_AHOLD;
        return PH_DONE;
    endfunction

    // cycles minus one spent in a phase; only called for phases of nonzero length
    function automatic logic [CNT_W-1:0] phase_len_m1(phase_e p, bank_timing_t c);
        logic [CNT_W-1:0] n;
        case (p)
            PH_ASET:  n = CNT_W'(c.tacs) - CNT_W'(1);
            PH_CSET:  n = CNT_W'(c.tcos) - CNT_W'(1);
            PH_ACC:   n = c.tacc;
            PH_PAGE:  n = (c.tacp == '0) ? '0 : CNT_W'(c.tacp) - CNT_W'(1);
            PH_CHOLD: n = CNT_W'(c.tcoh) - CNT_W'(1);
            PH_AHOLD: n = CNT_W'(c.tcah) - CNT_W'(1);
            default:  n = '0;
        endcase
        return n;
    endfunction

    function automatic logic cs_phase(phase_e p);
        return (p == PH_CSET) || (p == PH_ACC) || (p == PH_PAGE) || (p == PH_CHOLD);
    endfunction

    function automatic logic strobe_phase(phase_e p);
        return (p == PH_ACC) || (p == PH_PAGE);
    endfunction

endpackage

// File: rtl/smc_bank_select.sv
module smc_bank_select
    import smc_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BANK_W-1:0]         sel_bank,
    input  logic                      capture,
    input  logic                      busy,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tacs,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcos,
    input  logic [NBANK*ACC_W-1:0]    cfg_tacc,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcoh,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcah,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tacp,
    input  logic [NBANK-1:0]          cfg_wide,
    input  logic [NBANK-1:0]          cfg_page,
    output bank_timing_t              timing,
    output logic                      wide
);

    bank_timing_t bank_t [NBANK];
    bank_timing_t live_t;
    bank_timing_t held_t;
    logic         live_w;
    logic         held_w;

    for (genvar g = 0; g < NBANK; g++) begin : g_unpack
        assign bank_t[g] = '{
            tacs: cfg_tacs[g*SHORT_W +: SHORT_W],
            tcos: cfg_tcos[g*SHORT_W +: SHORT_W],
            tacc: cfg_tacc[g*ACC_W +: ACC_W],
            tcoh: cfg_tcoh[g*SHORT_W +: SHORT_W],
            tcah: cfg_tcah[g*SHORT_W +: SHORT_W],
            tacp: cfg_tacp[g*SHORT_W +: SHORT_W],
            page: cfg_page[g]
        };
    end

    assign live_t = bank_t[sel_bank];
    assign live_w = cfg_wide[sel_bank];

    always_ff @(posedge clk) begin
        if (rst) begin
            held_t <= '0;
            held_w <= 1'b0;
        end else if (capture) begin
            held_t <= live_t;
            held_w <= live_w;
        end
    end

    assign timing = busy ? held_t : live_t;
    assign wide   = busy ? held_w : live_w;

endmodule

// File: rtl/smc_sequencer.sv
module smc_sequencer
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bank_timing_t      timing,
    output phase_e            phase,
    output logic [BEAT_W-1:0] beat,
    output logic              beat_end,
    output logic              enter_page
);

    logic [CNT_W-1:0] cnt;
    logic             last;
    phase_e           nxt;

    assign last = (cnt == '0);

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE:  if (start) nxt = first_phase(timing);
            PH_ASET:  if (last) nxt = (timing.tcos != '0) ? PH_CSET : PH_ACC;
            PH_CSET:  if (last) nxt = PH_ACC;
            PH_ACC,
            PH_PAGE:  if (last) nxt = (timing.page && beat != BEAT_W'(BEATS-1))
                                      ? PH_PAGE : tail_phase(timing);
            PH_CHOLD: if (last) nxt = (timing.tcah != '0) ? PH_AHOLD : PH_DONE;
            PH_AHOLD: if (last) nxt = PH_DONE;
            PH_DONE:  nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    assign beat_end   = strobe_phase(phase) && last;
    assign enter_page = beat_end && (nxt == PH_PAGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            beat  <= '0;
        end else begin
            phase <= nxt;
            if ((nxt != phase) || enter_page)
                cnt <= phase_len_m1(nxt, timing);
            else if (!last)
                cnt <= cnt - CNT_W'(1);
            if (start && phase == PH_IDLE)
                beat <= '0;
            else if (enter_page)
                beat <= beat + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/smc_bus_io.sv
module smc_bus_io
    import smc_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [BEATS*DW-1:0] req_wdata,
    input  logic                wide,
    input  phase_e              phase,
    input  logic [BEAT_W-1:0]   beat,
    input  logic                beat_end,
    input  logic                enter_page,
    input  logic [DW-1:0]       mem_din,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [NBANK-1:0]    mem_cs_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DW-1:0]       mem_dout,
    output logic                mem_doe,
    output logic [BEATS*DW-1:0] rdata,
    output logic                ack
);

    logic [ADDR_W-1:0]   addr_r;
    logic [BANK_W-1:0]   bank_r;
    logic                wr_r;
    logic [BEATS*DW-1:0] wdata_r;
    logic [BEATS*DW-1:0] rdata_r;
    logic [DW-1:0]       wbeat;
    logic [DW-1:0]       rbeat;
    logic                cs_on;
    logic                strobe_on;

    assign cs_on     = cs_phase(phase);
    assign strobe_on = strobe_phase(phase);
    assign rbeat     = wide ? mem_din : {8'h00, mem_din[7:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r  <= '0;
            bank_r  <= '0;
            wr_r    <= 1'b0;
            wdata_r <= '0;
            rdata_r <= '0;
        end else if (start) begin
            addr_r  <= req_addr;
            bank_r  <= req_bank;
            wr_r    <= req_write;
            wdata_r <= req_wdata;
            rdata_r <= '0;
        end else begin
            if (enter_page)
                addr_r <= addr_r + (wide ? ADDR_W'(2) : ADDR_W'(1));
            if (beat_end && !wr_r)
                rdata_r[int'(beat)*DW +: DW] <= rbeat;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign mem_cs_n[g] = !(cs_on && (bank_r == BANK_W'(g)));
    end

    assign wbeat    = wdata_r[int'(beat)*DW +: DW];
    assign mem_addr = addr_r;
    assign mem_oe_n = !(strobe_on && !wr_r);
    assign mem_we_n = !(strobe_on && wr_r);
    assign mem_doe  = cs_on && wr_r;
    assign mem_dout = !mem_doe ? '0 : (wide ? wbeat : {8'h00, wbeat[7:0]});
    assign rdata    = rdata_r;
    assign ack      = (phase == PH_DONE);

endmodule

// File: rtl/smc_top.sv
module smc_top
    import smc_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic [BEATS*DW-1:0]       req_wdata,
    output logic                      ack,
    output logic [BEATS*DW-1:0]       rdata,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tacs,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcos,
    input  logic [NBANK*ACC_W-1:0]    cfg_tacc,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcoh,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tcah,
    input  logic [NBANK*SHORT_W-1:0]  cfg_tacp,
    input  logic [NBANK-1:0]          cfg_wide,
    input  logic [NBANK-1:0]          cfg_page,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [NBANK-1:0]          mem_cs_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [DW-1:0]             mem_dout,
    output logic                      mem_doe,
    input  logic [DW-1:0]             mem_din
);

    phase_e            phase;
    logic [BEAT_W-1:0] beat;
    logic              beat_end;
    logic              enter_page;
    logic              busy;
    logic              start;
    logic              wide;
    bank_timing_t      timing;

    assign busy  = (phase != PH_IDLE);
    assign start = req_valid && !busy;

    smc_bank_select #(.NBANK(NBANK), .BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .sel_bank (req_bank),
        .capture  (start),
        .busy     (busy),
        .cfg_tacs (cfg_tacs),
        .cfg_tcos (cfg_tcos),
        .cfg_tacc (cfg_tacc),
        .cfg_tcoh (cfg_tcoh),
        .cfg_tcah (cfg_tcah),
        .cfg_tacp (cfg_tacp),
        .cfg_wide (cfg_wide),
        .cfg_page (cfg_page),
        .timing   (timing),
        .wide     (wide)
    );

    smc_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .timing     (timing),
        .phase      (phase),
        .beat       (beat),
        .beat_end   (beat_end),
        .enter_page (enter_page)
    );

    smc_bus_io #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_io (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_bank   (req_bank),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .wide       (wide),
        .phase      (phase),
        .beat       (beat),
        .beat_end   (beat_end),
        .enter_page (enter_page),
        .mem_din    (mem_din),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dout   (mem_dout),
        .mem_doe    (mem_doe),
        .rdata      (rdata),
        .ack        (ack)
    );

endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NBANK-1:0]  mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_doe,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr
);

    p_one_cs_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> (!(&mem_cs_n) && (mem_oe_n || mem_we_n)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(&mem_cs_n) |-> $stable(mem_addr));

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_ack_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ack |-> ((&mem_cs_n) && mem_oe_n && mem_we_n && !mem_doe));

    p_drive_window_r9: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> (mem_oe_n && !(&mem_cs_n)));

endmodule

bind smc_top smc_checker #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_doe  (mem_doe),
    .ack      (ack),
    .mem_addr (mem_addr)
);

// File: tb/smc_top_tb.sv
`timescale 1ns/1ps
module smc_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        ack;
    logic [63:0] rdata;
    logic [15:0] cfg_tacs, cfg_tcos, cfg_tcoh, cfg_tcah, cfg_tacp;
    logic [19:0] cfg_tacc;
    logic [3:0]  cfg_wide, cfg_page;
    logic [15:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_doe;
    logic [15:0] mem_dout, mem_din;

    int t_acs[4], t_cos[4], t_acc[4], t_coh[4], t_cah[4], t_acp[4];
    bit b_wide[4], b_page[4];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            cfg_tacs[b*4 +: 4] = 4'(t_acs[b]);
            cfg_tcos[b*4 +: 4] = 4'(t_cos[b]);
            cfg_tacc[b*5 +: 5] = 5'(t_acc[b]);
            cfg_tcoh[b*4 +: 4] = 4'(t_coh[b]);
            cfg_tcah[b*4 +: 4] = 4'(t_cah[b]);
            cfg_tacp[b*4 +: 4] = 4'(t_acp[b]);
            cfg_wide[b] = b_wide[b];
            cfg_page[b] = b_page[b];
        end
    end

    function automatic logic [15:0] mem_fn(logic [15:0] a);
        return {a[7:0] ^ 8'h5A, ~a[7:0] ^ a[15:8]};
    endfunction

    assign mem_din = mem_fn(mem_addr);

    smc_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata),
        .cfg_tacs(cfg_tacs), .cfg_tcos(cfg_tcos), .cfg_tacc(cfg_tacc),
        .cfg_tcoh(cfg_tcoh), .cfg_tcah(cfg_tcah), .cfg_tacp(cfg_tacp),
        .cfg_wide(cfg_wide), .cfg_page(cfg_page),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din)
    );

    // {ack, doe, dout, we_n, oe_n, cs_n, addr}
    function automatic logic [39:0] vec(logic [15:0] a, logic [3:0] cs, logic oe, logic we,
                                        logic [15:0] d, logic doe, logic ak);
        return {ak, doe, d, we, oe, cs, a};
    endfunction

    function automatic logic [39:0] actual();
        return vec(mem_addr, mem_cs_n, mem_oe_n, mem_we_n, mem_dout, mem_doe, ack);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic txn(input int bank, input int base, input bit wr,
                       input logic [63:0] wd, input bit poke);
        logic [39:0] q[$];
        string       tq[$];
        logic [63:0] exp_rd = '0;
        logic [15:0] a = 16'(base);
        logic [15:0] d;
        logic [3:0]  csl = ~(4'b0001 << bank);
        int          step = b_wide[bank] ? 2 : 1;
        int          nbeat = b_page[bank] ? 4 : 1;
        int          plen = (t_acp[bank] == 0) ? 1 : t_acp[bank];
        string       sfx = poke ? "/R10/R11" : "";
        int          sv_acc, sv_cah;
        // R2 address setup
        repeat (t_acs[bank]) begin q.push_back(vec(a, 4'hF, 1, 1, 0, 0, 0)); tq.push_back({"R2", sfx}); end
        d = b_wide[bank] ? wd[15:0] : {8'h00, wd[7:0]};
        // R3 chip-select setup, R9 drive from here when writing
        repeat (t_cos[bank]) begin q.push_back(vec(a, csl, 1, 1, wr ? d : 16'h0, wr, 0)); tq.push_back({"R3/R9", sfx}); end
        for (int k = 0; k < nbeat; k++) begin
            int n = (k == 0) ? t_acc[bank] + 1 : plen;
            if (k > 0) a = a + 16'(step);
            d = b_wide[bank] ? wd[k*16 +: 16] : {8'h00, wd[k*16 +: 8]};
            exp_rd[k*16 +: 16] = b_wide[bank] ? mem_fn(a) : {8'h00, mem_fn(a)[7:0]};
            repeat (n) begin
                q.push_back(vec(a, csl, wr, !wr, wr ? d : 16'h0, wr, 0));
                tq.push_back({(k == 0) ? "R4/R9" : "R5/R9", sfx});
            end
        end
        repeat (t_coh[bank]) begin q.push_back(vec(a, csl, 1, 1, wr ? d : 16'h0, wr, 0)); tq.push_back({"R6/R9", sfx}); end
        repeat (t_cah[bank]) begin q.push_back(vec(a, 4'hF, 1, 1, 0, 0, 0)); tq.push_back({"R6", sfx}); end
        q.push_back(vec(a, 4'hF, 1, 1, 0, 0, 1)); tq.push_back({"R7", sfx});

        req_bank = 2'(bank); req_addr = 16'(base); req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        sv_acc = t_acc[bank]; sv_cah = t_cah[bank];
        for (int i = 0; i < q.size(); i++) begin
            check(tq[i], 64'(actual()), 64'(q[i]));
            if (i == q.size() - 1 && !wr) check({"R8", sfx}, rdata, exp_rd);
            if (poke) begin
                // R10: extra request while busy; R11: config changes mid-access
                req_valid = 1'b1; req_bank = 2'(bank ^ 1); req_addr = 16'(base + 16'h40);
                t_acc[bank] = 3; t_cah[bank] = 0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        t_acc[bank] = sv_acc; t_cah[bank] = sv_cah;
        check(poke ? "R10 idle after ack" : "R7 idle after ack", 64'(actual()),
              64'(vec(a, 4'hF, 1, 1, 0, 0, 0)));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R7 watchdog actual=hung expected=ack");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_acs = '{2, 0, 1, 15}; t_cos = '{1, 0, 2, 3};  t_acc = '{3, 0, 2, 31};
        t_coh = '{1, 0, 2, 0};  t_cah = '{2, 0, 1, 4};  t_acp = '{0, 0, 2, 0};
        b_wide = '{1, 0, 1, 0}; b_page = '{0, 0, 1, 1};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset", 64'(actual()), 64'(vec(16'h0, 4'hF, 1, 1, 0, 0, 0)));
        check("R1 rdata", rdata, 64'h0);
        @(negedge clk);

        txn(0, 16'h0120, 0, 64'h0, 0);                        // 16-bit single read
        txn(1, 16'h0033, 1, 64'h1111_2222_3333_44A5, 0);      // 8-bit write, all counts zero
        txn(1, 16'h00F0, 0, 64'h0, 0);                        // 8-bit read, zero counts
        txn(2, 16'h0200, 0, 64'h0, 0);                        // 16-bit page read
        txn(3, 16'h0301, 1, 64'hAB01_CD02_EF03_1204, 0);      // 8-bit page write, tacc max
        txn(2, 16'h0400, 1, 64'h0F0F_1234_5678_9ABC, 0);      // 16-bit page write
        txn(3, 16'h0050, 0, 64'h0, 0);                        // 8-bit page read
        txn(0, 16'h0500, 0, 64'h0, 1);                        // busy request + config change
        t_coh[2] = 15; t_cah[2] = 15; t_acp[2] = 15; t_acs[2] = 0; t_cos[2] = 15;
        txn(2, 16'h0600, 0, 64'h0, 0);                        // long holds
        txn(0, 16'h0700, 1, 64'h0000_0000_0000_BEEF, 1);      // write with busy request

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule